// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block takes an SDRAM device from reset to a usable state. While the device settles it holds the command bus at no-operation, keeps the clock enable high and drives every byte mask high, so the data pins stay high-impedance. After a long settling pause it issues one precharge to all banks. It then issues a fixed number of auto-refresh commands and a single load-mode command, in an order that one configuration input selects. Each command is followed by the recovery time it needs, counted in whole clock cycles rounded up from picosecond parameters.

The load-mode word comes from static configuration inputs: burst length, burst order, CAS latency and write mode. Unsupported codes are replaced with safe values and an error flag is raised. Once initialisation completes, the block raises a done flag and releases the byte masks. From then on it tracks refresh intervals and raises a request to the main controller. Each grant removes one owed refresh. A small saturating counter lets a few missed intervals be made up later.

Top module: `sdr_boot_seq`

## Requirements
- R1: Throughout reset and initialisation, the command bus carries no-operation (cs_n, ras_n, cas_n, we_n = 0,1,1,1) except on command cycles, sd_cke is 1, every sd_dqm bit is 1, and init_done and ref_req are 0.
- R2: The first command is a precharge-all (0,0,1,0 with sd_addr bit 10 = 1). It appears after exactly PAUSE_CYC = ceil(T_PAUSE_PS/CLK_PS) rising edges with reset low, and no command appears before it.
- R3: The command after the precharge comes exactly RP_CYC = ceil(T_RP_PS/CLK_PS) cycles after it.
- R4: Initialisation issues exactly INIT_REFS auto-refresh commands (0,0,0,1). Each one is followed by RC_CYC cycles before the next command, and the load-mode command is followed by MRD_CYC cycles.
- R5: When cfg_mrs_first is 1, the load-mode command (0,0,0,0) comes directly after the precharge, followed by the refreshes. When it is 0, all refreshes come first and the load-mode command comes last.
- R6: On the load-mode cycle, sd_ba is 0 and the mode word on sd_addr is set as follows: burst length in bits 2:0 (000=1, 001=2, 010=4, 011=8, 111=full page); burst order in bit 3 (0 sequential, 1 interleaved); CAS latency in bits 6:4 (010=2, 011=3); write mode in bit 9 (0 burst write, 1 single write). Bits 8:7 and 11:10 are 0.
- R7: A burst-length code of 100, 101 or 110 is sent as 011. A CAS-latency code other than 010 or 011 is sent as 011. cfg_err is 1 from the first edge after reset whenever either code is unsupported, and 0 otherwise.
- R8: init_done rises, and sd_dqm drops to all zeros, on the edge that comes exactly the last command's recovery time after that command. After this the bus stays at no-operation and init_done stays 1.
- R9: ref_req is 1 exactly REFI_CYC = ceil(T_REFI_PS/CLK_PS) edges after init_done rises. Every further REFI_CYC edges, one more owed refresh is added.
- R10: A ref_gnt cycle while refreshes are owed removes exactly one. ref_req falls only after the last owed refresh is granted. A grant while none are owed has no effect.
- R11: The count of owed refreshes saturates at PEND_MAX. After any number of ungranted intervals, exactly PEND_MAX grants clear ref_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | Burst order: 1 interleaved |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_single_write | input | 1 | Write mode: 1 single write |
| cfg_mrs_first | input | 1 | 1: load-mode before the refreshes |
| ref_gnt | input | 1 | Controller has taken one refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address / mode word |
| sd_ba | output | BA_W | Bank address |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Byte masks |
| init_done | output | 1 | Initialisation complete |
| ref_req | output | 1 | At least one refresh owed |
| cfg_err | output | 1 | Unsupported configuration code seen |

## Verification
The start-up sequence is run under both settings of the order bit, with directed mode settings that include full-page interleaved single-write and an invalid burst and latency pair, and with seeded random configurations. These runs separate correct field placement and code substitution from shifted or unfiltered fields, and they pin every command to its exact cycle. The refresh side is driven with several patterns: grants held back over several intervals, a grant while nothing is owed, and a long ungranted stretch. These expose a wrong interval, a lost or doubled grant, an underflow, and missing saturation.

// File: rtl/sdr_boot_pkg.sv
package sdr_boot_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE  = 4'b0000,
    CMD_AREF  = 4'b0001,
    CMD_PRALL = 4'b0010,
    CMD_IDLE  = 4'b0111
  } sdr_cmd_e;

  localparam logic [2:0] BL_FALLBACK = 3'b011;
  localparam logic [2:0] CL_FALLBACK = 3'b011;

  // Cycles needed to cover a time in ps, rounded up, never below one.
  function automatic int cyc_of(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic bl_ok(input logic [2:0] code);
    return (code inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111});
  endfunction

  function automatic logic cl_ok(input logic [2:0] code);
    return (code inside {3'b010, 3'b011});
  endfunction

endpackage

// File: rtl/sdr_mode_word.sv
module sdr_mode_word
  import sdr_boot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        burst_len,
  input  logic              interleave,
  input  logic [2:0]        cas_lat,
  input  logic              single_write,
  output logic [ADDR_W-1:0] word,
  output logic              bad_code
);

  logic [2:0] bl_fix;
  logic [2:0] cl_fix;

  always_comb begin
    bl_fix   = bl_ok(burst_len) ? burst_len : BL_FALLBACK;
    cl_fix   = cl_ok(cas_lat)   ? cas_lat   : CL_FALLBACK;
    bad_code = !bl_ok(burst_len) || !cl_ok(cas_lat);
    word      = '0;
    word[2:0] = bl_fix;
    word[3]   = interleave;
    word[6:4] = cl_fix;
    word[9]   = single_write;
  end

endmodule

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdr_refresh_due.sv
module sdr_refresh_due #(
  parameter int REFI_CYC = 3907,
  parameter int PEND_MAX = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic gnt,
  output logic req
);

  localparam int TW = $clog2(REFI_CYC + 1);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [TW-1:0] tmr_q;
  logic [PW-1:0] owed_q;
  logic [PW-1:0] owed_d;
  logic          tick;
  logic          add;
  logic          take;

  assign tick = run && (tmr_q == TW'(REFI_CYC - 1));
  assign add  = tick && (owed_q != PW'(PEND_MAX));
  assign take = gnt && (owed_q != '0);

  always_comb begin
    owed_d = owed_q;
    if (add && !take) begin
      owed_d = owed_q + 1'b1;
    end else if (take && !add) begin
      owed_d = owed_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q  <= '0;
      owed_q <= '0;
      req    <= 1'b0;
    end else begin
      if (run) begin
        tmr_q <= tick ? '0 : tmr_q + 1'b1;
      end
      owed_q <= owed_d;
      req    <= (owed_d != '0);
    end
  end

endmodule

// File: rtl/sdr_boot_seq.sv
module sdr_boot_seq
  import sdr_boot_pkg::*;
#(
  parameter int CLK_PS     = 4000,
  parameter int T_PAUSE_PS = 200_000_000,
  parameter int T_RP_PS    = 20_000,
  parameter int T_RC_PS    = 68_000,
  parameter int T_MRD_PS   = 16_000,
  parameter int T_REFI_PS  = 15_625_000,
  parameter int INIT_REFS  = 8,
  parameter int PEND_MAX   = 4,
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int DQM_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic              cfg_single_write,
  input  logic              cfg_mrs_first,
  input  logic              ref_gnt,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba,
  output logic              sd_cke,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done,
  output logic              ref_req,
  output logic              cfg_err
);

  localparam int PAUSE_CYC = cyc_of(T_PAUSE_PS, CLK_PS);
  localparam int RP_CYC    = cyc_of(T_RP_PS, CLK_PS);
  localparam int RC_CYC    = cyc_of(T_RC_PS, CLK_PS);
  localparam int MRD_CYC   = cyc_of(T_MRD_PS, CLK_PS);
  localparam int REFI_CYC  = cyc_of(T_REFI_PS, CLK_PS);
  localparam int GAP_MAX   = (PAUSE_CYC > RC_CYC) ? PAUSE_CYC : RC_CYC;
  localparam int CNT_W     = $clog2(GAP_MAX + 1);
  localparam int FIN_STEP  = INIT_REFS + 2;
  localparam int STEP_W    = $clog2(FIN_STEP + 1);
  localparam int AP_BIT    = 10;

  logic [STEP_W-1:0] step_q;
  logic              done_q;
  sdr_cmd_e          cmd_q;
  sdr_cmd_e          step_cmd;
  logic [CNT_W-1:0]  step_gap;
  logic              gap_over;
  logic              advance;
  logic              mode_slot;
  logic [ADDR_W-1:0] mode_word;
  logic              mode_bad;

  sdr_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .burst_len    (cfg_burst_len),
    .interleave   (cfg_interleave),
    .cas_lat      (cfg_cas_lat),
    .single_write (cfg_single_write),
    .word         (mode_word),
    .bad_code     (mode_bad)
  );

  assign advance = !done_q && gap_over;

  sdr_gap_timer #(.CNT_W(CNT_W), .RST_VAL(PAUSE_CYC - 1)) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (advance),
    .load_val (step_gap),
    .expired  (gap_over)
  );

  // Which step holds the load-mode command depends on the order bit.
  assign mode_slot = cfg_mrs_first ? (step_q == STEP_W'(1))
                                   : (step_q == STEP_W'(INIT_REFS + 1));

  always_comb begin
    if (step_q == '0) begin
      step_cmd = CMD_PRALL;
      step_gap = CNT_W'(RP_CYC - 1);
    end else if (step_q == STEP_W'(FIN_STEP)) begin
      step_cmd = CMD_IDLE;
      step_gap = '0;
    end else if (mode_slot) begin
      step_cmd = CMD_MODE;
      step_gap = CNT_W'(MRD_CYC - 1);
    end else begin
      step_cmd = CMD_AREF;
      step_gap = CNT_W'(RC_CYC - 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      done_q  <= 1'b0;
      cmd_q   <= CMD_IDLE;
      sd_addr <= '0;
      sd_ba   <= '0;
      sd_dqm  <= '1;
      sd_cke  <= 1'b1;
      cfg_err <= 1'b0;
    end else begin
      sd_cke  <= 1'b1;
      cfg_err <= mode_bad;
      cmd_q   <= CMD_IDLE;
      sd_addr <= '0;
      sd_ba   <= '0;
      if (advance) begin
        cmd_q <= step_cmd;
        if (step_cmd == CMD_PRALL) begin
          sd_addr[AP_BIT] <= 1'b1;
        end else if (step_cmd == CMD_MODE) begin
          sd_addr <= mode_word;
        end
        if (step_q == STEP_W'(FIN_STEP)) begin
          done_q <= 1'b1;
          sd_dqm <= '0;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign sd_cs_n   = cmd_q[3];
  assign sd_ras_n  = cmd_q[2];
  assign sd_cas_n  = cmd_q[1];
  assign sd_we_n   = cmd_q[0];
  assign init_done = done_q;

  sdr_refresh_due #(.REFI_CYC(REFI_CYC), .PEND_MAX(PEND_MAX)) u_due (
    .clk (clk),
    .rst (rst),
    .run (done_q),
    .gnt (ref_gnt),
    .req (ref_req)
  );

endmodule

// File: rtl/sdr_boot_chk.sv
module sdr_boot_chk #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int DQM_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_gnt,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [ADDR_W-1:0] sd_addr,
  input logic [BA_W-1:0]   sd_ba,
  input logic              sd_cke,
  input logic [DQM_W-1:0]  sd_dqm,
  input logic              init_done,
  input logic              ref_req
);

  logic [3:0] cmd;
  assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  assert_masks_high_R1: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (sd_cke && (&sd_dqm)));

  assert_prall_ap_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> sd_addr[10]);

  assert_mode_fields_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> (sd_addr[8:7] == 2'b00 && sd_addr[11:10] == 2'b00 && sd_ba == '0));

  assert_mode_codes_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000) |-> ((sd_addr[6:4] inside {3'b010, 3'b011}) &&
                          !(sd_addr[2:0] inside {3'b100, 3'b101, 3'b110})));

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd == 4'b0111 && sd_dqm == '0));

  assert_done_sticks_R8: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_no_early_req_R9: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !ref_req);

  assert_req_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req);

endmodule

bind sdr_boot_seq sdr_boot_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_gnt   (ref_gnt),
  .sd_cs_n   (sd_cs_n),
  .sd_ras_n  (sd_ras_n),
  .sd_cas_n  (sd_cas_n),
  .sd_we_n   (sd_we_n),
  .sd_addr   (sd_addr),
  .sd_ba     (sd_ba),
  .sd_cke    (sd_cke),
  .sd_dqm    (sd_dqm),
  .init_done (init_done),
  .ref_req   (ref_req)
);

// File: tb/sim_sdr_boot_seq.sv
`timescale 1ns/1ps
module sim_sdr_boot_seq;

  localparam int CLK_PS  = 4000;
  localparam int PAUSE_PS = 2_000_000;
  localparam int RP_PS   = 20_000;
  localparam int RC_PS   = 68_000;
  localparam int MRD_PS  = 16_000;
  localparam int REFI_PS = 1_000_000;
  localparam int NREF    = 8;
  localparam int PMAX    = 4;

  localparam int P   = (PAUSE_PS + CLK_PS - 1) / CLK_PS;
  localparam int RP  = (RP_PS + CLK_PS - 1) / CLK_PS;
  localparam int RC  = (RC_PS + CLK_PS - 1) / CLK_PS;
  localparam int MRD = (MRD_PS + CLK_PS - 1) / CLK_PS;
  localparam int RI  = (REFI_PS + CLK_PS - 1) / CLK_PS;
  localparam int D   = P + RP + NREF * RC + MRD;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cfg_burst_len = 3'b011;
  logic cfg_interleave = 1'b0;
  logic [2:0] cfg_cas_lat = 3'b010;
  logic cfg_single_write = 1'b0;
  logic cfg_mrs_first = 1'b0;
  logic ref_gnt = 1'b0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [11:0] sd_addr;
  logic [1:0] sd_ba;
  logic sd_cke;
  logic [7:0] sd_dqm;
  logic init_done, ref_req, cfg_err;

  int checks = 0;
  int fails = 0;
  int n = 0;

  always #2 clk = ~clk;

  sdr_boot_seq #(
    .CLK_PS(CLK_PS), .T_PAUSE_PS(PAUSE_PS), .T_RP_PS(RP_PS), .T_RC_PS(RC_PS),
    .T_MRD_PS(MRD_PS), .T_REFI_PS(REFI_PS), .INIT_REFS(NREF), .PEND_MAX(PMAX)
  ) u0 (
    .clk(clk), .rst(rst), .cfg_burst_len(cfg_burst_len), .cfg_interleave(cfg_interleave),
    .cfg_cas_lat(cfg_cas_lat), .cfg_single_write(cfg_single_write),
    .cfg_mrs_first(cfg_mrs_first), .ref_gnt(ref_gnt),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_cke(sd_cke), .sd_dqm(sd_dqm),
    .init_done(init_done), .ref_req(ref_req), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_cmd(input int t, input bit mf);
    int at;
    bit is_mode;
    if (t == P) return 4'b0010;
    at = P + RP;
    for (int i = 0; i <= NREF; i++) begin
      is_mode = mf ? (i == 0) : (i == NREF);
      if (t == at) return is_mode ? 4'b0000 : 4'b0001;
      at += is_mode ? MRD : RC;
    end
    return 4'b0111;
  endfunction

  function automatic logic [11:0] exp_word(input logic [2:0] bl, input bit il,
                                           input logic [2:0] cl, input bit sw);
    logic [2:0] b;
    logic [2:0] c;
    b = (bl inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7}) ? bl : 3'b011;
    c = (cl inside {3'd2, 3'd3}) ? cl : 3'b011;
    return {2'b00, sw, 2'b00, c, il, b};
  endfunction

  function automatic bit exp_err(input logic [2:0] bl, input logic [2:0] cl);
    return !(bl inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7}) || !(cl inside {3'd2, 3'd3});
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    n++;
  endtask

  task automatic wait_to(input int t);
    while (n < t) step();
  endtask

  task automatic grant();
    ref_gnt = 1'b1;
    step();
    ref_gnt = 1'b0;
  endtask

  task automatic run_init(input logic [2:0] bl, input bit il, input logic [2:0] cl,
                          input bit sw, input bit mf);
    logic [3:0] c;
    logic [3:0] e;
    int refs;
    refs = 0;
    cfg_burst_len = bl; cfg_interleave = il; cfg_cas_lat = cl;
    cfg_single_write = sw; cfg_mrs_first = mf;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n = 0;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    chk(c == 4'b0111 && sd_cke && sd_dqm == 8'hff && !init_done && !ref_req,
        "R1", "reset state", {c, sd_dqm}, 12'h7ff);
    while (n < D + 2) begin
      step();
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      e = exp_cmd(n, mf);
      if (n == 1) chk(cfg_err == exp_err(bl, cl), "R7", "cfg_err", cfg_err, exp_err(bl, cl));
      if (c == 4'b0001) refs++;
      if (e == 4'b0010) begin
        chk(c == e && sd_addr[10], "R2", "precharge-all at pause end", c, e);
      end else if (n == P + RP) begin
        chk(c == e, "R3", "first command after precharge gap", c, e);
        if (c == 4'b0000)
          chk(sd_addr == exp_word(bl, il, cl, sw) && sd_ba == 0, "R6", "mode word",
              sd_addr, exp_word(bl, il, cl, sw));
      end else if (e == 4'b0000) begin
        chk(c == e, "R5", "load-mode position", c, e);
        chk(sd_addr == exp_word(bl, il, cl, sw) && sd_ba == 0, "R6", "mode word",
            sd_addr, exp_word(bl, il, cl, sw));
        if (exp_err(bl, cl))
          chk(sd_addr == exp_word(bl, il, cl, sw), "R7", "substituted codes",
              sd_addr, exp_word(bl, il, cl, sw));
      end else if (e == 4'b0001) begin
        chk(c == e, "R5", "refresh position", c, e);
      end else if (c != e) begin
        chk(1'b0, "R4", "stray command in gap", c, e);
      end
      if (n < D && (init_done || !sd_cke || sd_dqm != 8'hff || ref_req))
        chk(1'b0, "R1", "init-phase outputs", {init_done, sd_dqm}, 12'h0ff);
      if (n == D - 1) chk(!init_done, "R8", "done not early", init_done, 0);
      if (n == D) chk(init_done && sd_dqm == 0, "R8", "done and masks off",
                      {init_done, sd_dqm}, 12'h100);
    end
    chk(refs == NREF, "R4", "refresh count", refs, NREF);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Directed: refreshes first, 8-beat sequential, CL2, burst write.
    run_init(3'b011, 1'b0, 3'b010, 1'b0, 1'b0);

    // Refresh request timing and grant handling on this run.
    wait_to(D + RI - 1);
    chk(!ref_req, "R9", "request not early", ref_req, 0);
    step();
    chk(ref_req, "R9", "request after one interval", ref_req, 1);
    wait_to(D + 3 * RI);
    chk(ref_req, "R9", "still owed, three intervals", ref_req, 1);
    grant();
    chk(ref_req, "R10", "two owed after one grant", ref_req, 1);
    grant();
    chk(ref_req, "R10", "one owed after two grants", ref_req, 1);
    grant();
    chk(!ref_req, "R10", "cleared after three grants", ref_req, 0);
    grant();
    step();
    chk(!ref_req, "R10", "idle grant ignored", ref_req, 0);
    wait_to(D + 4 * RI);
    chk(ref_req, "R10", "next tick owes exactly one", ref_req, 1);
    grant();
    chk(!ref_req, "R10", "single grant clears", ref_req, 0);
    wait_to(D + 10 * RI);
    chk(ref_req, "R11", "owed after six intervals", ref_req, 1);
    for (int g = 1; g <= PMAX; g++) begin
      grant();
      if (g < PMAX) chk(ref_req, "R11", "still owed below cap", g, PMAX);
      else chk(!ref_req, "R11", "cleared at saturation cap", ref_req, 0);
    end

    // Directed: mode first, full page interleaved, CL3, single write.
    run_init(3'b111, 1'b1, 3'b011, 1'b1, 1'b1);
    // Directed: unsupported burst and latency codes.
    run_init(3'b101, 1'b0, 3'b001, 1'b0, 1'b1);
    // Seeded random configurations.
    for (int k = 0; k < 4; k++) begin
      run_init(3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule